// File: doc/BRIEF.md
# Completion Poll Sequencer for Flash Program and Erase

This block runs on the host side of a byte-wide flash device and decides whether a program or erase job that has already been launched finished cleanly or failed. After a start pulse it keeps reading one byte at a fixed address through a request/acknowledge read port. Each returned byte is judged on two bits: a completion bit, which the device drives to the inverse of the final value while the job runs, and a timeout bit, which the device raises when its internal algorithm gives up.

The caller supplies the value the completion bit should end at. For a program job this is the programmed value of that bit; for an erase job it is 1. The caller also supplies an address the device will report status on. For a program job this is the programmed address. For a sector erase it is any address in a sector picked for erase, and for a whole-device erase it is any unprotected address. The completion bit can settle before the other seven bits. A match therefore triggers one extra settling read, and that byte is the one handed back with the verdict. The timeout bit and the completion bit can flip together, so a raised timeout bit leads to one recheck read before a failure is declared. A limit on the number of polls, set by a parameter, keeps a silent device from hanging the sequencer.

Top module: `dpoll_checker`

## Requirements
- R1: While reset is held and after it is released, `rd_req_o`, `done_o`, `pass_o`, `fail_o` and `result_o` are all 0.
- R2: A start pulse in the idle state captures `addr_i` and `expect_i`. `rd_req_o` rises on the next cycle, and `rd_addr_o` holds the captured address until the verdict.
- R3: When a poll read returns bit 7 equal to the captured expected value, exactly one more read follows (the settling read). Then the sequencer reports pass, with `result_o` equal to the byte of that settling read.
- R4: When a poll read returns a bit 7 mismatch with bit 5 at 0, another poll read of the same address follows.
- R5: When a poll read returns a bit 7 mismatch with bit 5 at 1, one recheck read follows. If bit 7 matches on the recheck, the settling read and pass follow as in R3. If it mismatches, the verdict is fail.
- R6: Bit 5 has no effect on a read whose bit 7 matches the expected value. Such a read always leads to the settling read.
- R7: `done_o` is high for exactly one cycle, in the cycle after the acknowledge of the last read. Exactly one of `pass_o` and `fail_o` is high with it, and both are 0 whenever `done_o` is 0. `rd_req_o` is 0 while `done_o` is high.
- R8: A start pulse while a poll job is active is ignored. The captured address, the expected value and the job's outcome are unchanged.
- R9: With `MAX_POLLS` nonzero, the `MAX_POLLS`-th poll read that returns a bit 7 mismatch with bit 5 at 0 ends the job with fail. A match on an earlier poll still passes. With `MAX_POLLS` at 0 there is no limit.
- R10: `rd_req_o` stays high until `rd_ack_i` is seen. `rd_data_i` is sampled only in cycles where both are high, so any number of wait cycles per read is allowed.
- R11: On a fail verdict, `result_o` holds the byte returned by the last read of the job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a poll job |
| expect_i | input | 1 | Final value expected on bit 7 |
| addr_i | input | ADDR_W | Address the device reports status on |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; `rd_data_i` is valid in this cycle |
| rd_data_i | input | DATA_W | Byte returned by the device |
| done_o | output | 1 | One-cycle verdict strobe |
| pass_o | output | 1 | Job passed, qualified by `done_o` |
| fail_o | output | 1 | Job failed, qualified by `done_o` |
| result_o | output | DATA_W | Settling-read byte on pass, last byte on fail |

## Verification
The read sequences cover these cases:
- An immediate match, which tells a direct pass from any path that reads more than once.
- A run of mismatches with bit 5 low, which proves that polling repeats.
- Bit 5 raised together with a mismatch and then a recheck that matches, which separates the recheck path from an early fail.
- Bit 5 raised with a recheck that mismatches, including after earlier plain mismatches.

Matches that carry bit 5 set show that bit 5 is ignored on a match. Both expected values are used, so an inverted comparison cannot pass. Each case counts the reads the device model answers and checks the returned byte, which exposes a missing settling read or a recheck that is skipped. Further directed runs cover:
- acknowledge wait cycles;
- a start pulse in the middle of a job;
- the poll limit, hit exactly and approached but not reached.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_POLL   = 2'd1,
        ST_RECHK  = 2'd2,
        ST_SETTLE = 2'd3
    } dpc_state_e;

    typedef struct packed {
        logic match;    // completion bit equals expected value
        logic timeout;  // device timeout bit raised
    } dpc_class_t;

endpackage

// File: rtl/dpc_classify.sv
module dpc_classify
    import dpc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DONE_BIT = 7,
    parameter int TMO_BIT  = 5
) (
    input  logic [DATA_W-1:0] byte_i,
    input  logic              expect_i,
    output dpc_class_t        class_o
);

    always_comb begin
        class_o.match   = (byte_i[DONE_BIT] == expect_i);
        class_o.timeout = byte_i[TMO_BIT];
    end

endmodule

// File: rtl/dpc_poll_limit.sv
module dpc_poll_limit #(
    parameter int MAX_POLLS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic bump_i,
    output logic expired_o
);

    generate
        if (MAX_POLLS == 0) begin : g_unlimited
            assign expired_o = 1'b0;
        end else begin : g_limited
            localparam int CNT_W = $clog2(MAX_POLLS + 1);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);

            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clear_i) begin
                    cnt_d = '0;
                end else if (bump_i && (cnt_q != LAST)) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign expired_o = bump_i && (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/dpoll_checker.sv
module dpoll_checker
    import dpc_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int DONE_BIT  = 7,
    parameter int TMO_BIT   = 5,
    parameter int MAX_POLLS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              expect_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic [DATA_W-1:0] result_o
);

    typedef struct packed {
        dpc_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              expect_v;
        logic              req;
        logic              done;
        logic              pass;
        logic              fail;
        logic [DATA_W-1:0] result;
    } regs_t;

    regs_t      r_d, r_q;
    dpc_class_t cls;
    logic       poll_clear, poll_bump, poll_expired;

    dpc_classify #(
        .DATA_W  (DATA_W),
        .DONE_BIT(DONE_BIT),
        .TMO_BIT (TMO_BIT)
    ) u_classify (
        .byte_i  (rd_data_i),
        .expect_i(r_q.expect_v),
        .class_o (cls)
    );

    dpc_poll_limit #(
        .MAX_POLLS(MAX_POLLS)
    ) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (poll_clear),
        .bump_i   (poll_bump),
        .expired_o(poll_expired)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.pass   = 1'b0;
        r_d.fail   = 1'b0;
        poll_clear = 1'b0;
        poll_bump  = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state    = ST_POLL;
                    r_d.addr     = addr_i;
                    r_d.expect_v = expect_i;
                    r_d.req      = 1'b1;
                    poll_clear   = 1'b1;
                end
            end
            ST_POLL: begin
                if (rd_ack_i) begin
                    r_d.result = rd_data_i;
                    if (cls.match) begin
                        r_d.state = ST_SETTLE;
                    end else if (cls.timeout) begin
                        r_d.state = ST_RECHK;
                    end else begin
                        poll_bump = 1'b1;
                        if (poll_expired) begin
                            r_d.state = ST_IDLE;
                            r_d.req   = 1'b0;
                            r_d.done  = 1'b1;
                            r_d.fail  = 1'b1;
                        end
                    end
                end
            end
            ST_RECHK: begin
                if (rd_ack_i) begin
                    r_d.result = rd_data_i;
                    if (cls.match) begin
                        r_d.state = ST_SETTLE;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.req   = 1'b0;
                        r_d.done  = 1'b1;
                        r_d.fail  = 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (rd_ack_i) begin
                    r_d.result = rd_data_i;
                    r_d.state  = ST_IDLE;
                    r_d.req    = 1'b0;
                    r_d.done   = 1'b1;
                    r_d.pass   = 1'b1;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.req   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.addr     <= '0;
            r_q.expect_v <= 1'b0;
            r_q.req      <= 1'b0;
            r_q.done     <= 1'b0;
            r_q.pass     <= 1'b0;
            r_q.fail     <= 1'b0;
            r_q.result   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req_o  = r_q.req;
    assign rd_addr_o = r_q.addr;
    assign done_o    = r_q.done;
    assign pass_o    = r_q.pass;
    assign fail_o    = r_q.fail;
    assign result_o  = r_q.result;

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_o,
    input logic              rd_ack_i,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              done_o,
    input logic              pass_o,
    input logic              fail_o
);

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o ^ fail_o)) else $error("one verdict"); // R7

    AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!pass_o && !fail_o)) else $error("flags"); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done pulse"); // R7

    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_req_o) else $error("req at done"); // R7

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && $past(rd_req_o)) |-> $stable(rd_addr_o)) else $error("addr"); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o || done_o)) else $error("req drop"); // R10

endmodule

bind dpoll_checker dpc_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_dpc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req_o (rd_req_o),
    .rd_ack_i (rd_ack_i),
    .rd_addr_o(rd_addr_o),
    .done_o   (done_o),
    .pass_o   (pass_o),
    .fail_o   (fail_o)
);

// File: tb/dpoll_checker_bench.sv
module dpoll_checker_bench;

    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int LIMIT  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              expect_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              rd_req_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic              rd_ack_i = 1'b0;
    logic [DATA_W-1:0] rd_data_i = '0;
    logic              done_o, pass_o, fail_o;
    logic [DATA_W-1:0] result_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dpoll_checker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_POLLS(LIMIT)
    ) u_dpoll_checker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .expect_i(expect_i),
        .addr_i(addr_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .done_o(done_o),
        .pass_o(pass_o), .fail_o(fail_o), .result_o(result_o)
    );

    // device model: answers requests from a script, optional wait cycles
    logic [7:0]        script [16];
    int                idx = 0;
    logic              gap = 1'b0;
    logic              phase = 1'b0;
    logic [ADDR_W-1:0] cur_addr = '0;
    int                addr_err = 0;

    always @(negedge clk) begin
        if (rd_req_o && (!gap || phase)) begin
            rd_ack_i  <= 1'b1;
            rd_data_i <= script[idx];
            idx       <= idx + 1;
            if (rd_addr_o != cur_addr) addr_err <= addr_err + 1;
        end else begin
            rd_ack_i  <= 1'b0;
            rd_data_i <= 8'hEE;
        end
        phase <= rd_req_o ? ~phase : 1'b0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // run one job; the script must be filled beforehand
    task automatic run_job(input logic ex, input logic [ADDR_W-1:0] a, input logic g,
                           input bit exp_pass, input int exp_reads, input logic [7:0] exp_res,
                           input bit poke_start, input string req);
        int waited;
        @(negedge clk);
        idx = 0; gap = g; addr_err = 0; cur_addr = a;
        expect_i = ex; addr_i = a; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(rd_req_o == 1'b1, "R2 req after start", rd_req_o, 1);
        if (poke_start) begin
            @(negedge clk);
            expect_i = ~ex; addr_i = ~a; start_i = 1'b1;   // R8: must be ignored
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        check(done_o == 1'b1, {req, " done seen"}, done_o, 1);
        check(pass_o == exp_pass && fail_o == !exp_pass, {req, " verdict (R7)"},
              {pass_o, fail_o}, {exp_pass, !exp_pass});
        check(idx == exp_reads, {req, " read count"}, idx, exp_reads);
        check(result_o == exp_res, {req, " result byte (R3/R11)"}, result_o, exp_res);
        check(addr_err == 0, {req, " address held (R2)"}, addr_err, 0);
        check(rd_req_o == 1'b0, "R7 req low at done", rd_req_o, 0);
        @(negedge clk);
        check(done_o == 1'b0 && pass_o == 1'b0 && fail_o == 1'b0, "R7 single-cycle done",
              {done_o, pass_o, fail_o}, 0);
    endtask

    typedef struct packed {
        logic        ex;
        logic [47:0] bytes;
        logic        g;
        logic        pas;
        logic [3:0]  reads;
        logic [7:0]  res;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 48'h0000_0000_A580, 1'b0, 1'b1, 4'd2, 8'hA5},  // R3 direct match
        '{1'b0, 48'h0000_003C_0080, 1'b1, 1'b1, 4'd3, 8'h3C},  // R4 retry then match, waits R10
        '{1'b1, 48'h0000_0011_8020, 1'b0, 1'b1, 4'd3, 8'h11},  // R5 recheck matches
        '{1'b1, 48'h0000_0000_2020, 1'b1, 1'b0, 4'd2, 8'h20},  // R5 recheck mismatches, R11
        '{1'b1, 48'h0000_0020_0000, 1'b0, 1'b0, 4'd4, 8'h00},  // R4 then R5 fail
        '{1'b0, 48'h0000_0042_7FA0, 1'b0, 1'b1, 4'd3, 8'h42},  // R5 expect 0 recheck ok
        '{1'b0, 48'h0000_0000_FF7F, 1'b1, 1'b1, 4'd2, 8'hFF}   // R6 bit 5 ignored on match
    };

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) script[i] = 8'hEE;
        // R1 reset state
        repeat (3) @(negedge clk);
        check({rd_req_o, done_o, pass_o, fail_o, result_o} == '0, "R1 in reset",
              {rd_req_o, done_o, pass_o, fail_o, result_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({rd_req_o, done_o, pass_o, fail_o, result_o} == '0, "R1 after reset",
              {rd_req_o, done_o, pass_o, fail_o, result_o}, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            for (int b = 0; b < 6; b++) script[b] = VECS[v].bytes[b*8 +: 8];
            run_job(VECS[v].ex, ADDR_W'(17'h10000 + v), VECS[v].g, VECS[v].pas,
                    int'(VECS[v].reads), VECS[v].res, 1'b0, $sformatf("vec%0d", v));
        end

        // R8: start mid-job ignored, with R10 wait cycles
        script[0] = 8'h00; script[1] = 8'h00; script[2] = 8'h00;
        script[3] = 8'h80; script[4] = 8'h5A;
        run_job(1'b1, 17'h0ABCD, 1'b1, 1'b1, 5, 8'h5A, 1'b1, "R8 start ignored");

        // R9: limit hit exactly
        for (int b = 0; b < 16; b++) script[b] = 8'h00;
        run_job(1'b1, 17'h00123, 1'b0, 1'b0, LIMIT, 8'h00, 1'b0, "R9 limit reached");

        // R9: one short of the limit, then a match
        for (int b = 0; b < LIMIT - 1; b++) script[b] = 8'h00;
        script[LIMIT-1] = 8'h80;
        script[LIMIT]   = 8'h66;
        run_job(1'b1, 17'h00456, 1'b0, 1'b1, LIMIT + 1, 8'h66, 1'b0, "R9 below limit");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule